// File: doc/BRIEF.md
# Push-Pull PWM Output Steering Controller

This block is the digital core of a two-phase push-pull pulse-width modulator. A free-running ramp counter divides time into switching periods of a fixed number of clock cycles. Each period opens with a short quiet interval in which both drive outputs are held low. After that interval, the drive pulse stays high while the ramp is below a duty command word. The command is captured once, at the start of each period. A steering flip-flop sends each pulse to one of the two outputs, so the two sides of the transformer are driven in turn.

Three asynchronous control inputs each pass through a two-stage synchronizer. The first is a restart strobe, which lets an external clock end the current period early. The free-running period is normally set about ten percent longer than the strobe period, so the strobe always wins. The other two are a shutdown level and a current-limit level, and either one kills the drive pulse. Once a pulse has ended in a period, it cannot come back in that period. The steering flip-flop only moves at the end of a period that actually produced a pulse. As a result, neither output is ever driven twice in a row, even across a shutdown.

Top module: `pp_pwm_steer`

## Requirements
- R1: While `rst` is high and after its release, `out_a` and `out_b` are low, `phase` is 0 and the ramp is at 0.
- R2: Without restart strobes, the ramp counts 0 to PERIOD-1 and wraps, so the output pattern repeats every PERIOD clock cycles.
- R3: While the ramp is below DEAD (DEAD at least 1), both outputs are low.
- R4: The selected output is high exactly when DEAD <= ramp < duty_q, where duty_q is the command captured at the start of the period. A command at or below DEAD gives 0% duty. A command of PERIOD or more gives the largest pulse, ramp DEAD to PERIOD-1.
- R5: `duty_cmd` is captured only on the cycle the ramp restarts. A change during a period has no effect until the next period.
- R6: `phase` = 0 steers the pulse to `out_a` and `phase` = 1 steers it to `out_b`. The two outputs are never high together.
- R7: `phase` inverts at a period restart if, and only if, the period that is ending produced at least one high output cycle. It never changes at any other time.
- R8: When `shdn_in` or `ilim_in` is high at a rising edge k, both outputs are low after edge k+2. They stay low while the synchronized level stays high.
- R9: Once a pulse has gone low within a period, no output goes high again before the next period restart, whatever the stop inputs or the ramp do.
- R10: Two consecutive output pulses never appear on the same output. This includes the pulses on either side of a shutdown.
- R11: If `sync_in` is first sampled high at edge k after having been low, the ramp is 0 after edge k+2. That restart also captures the duty command and may steer as in R5 and R7. A strobe that is seen at even one rising edge is accepted. A level that is held high causes only one restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | CNT_W | Duty command word compared with the ramp |
| sync_in | input | 1 | Asynchronous period restart strobe |
| shdn_in | input | 1 | Asynchronous shutdown level |
| ilim_in | input | 1 | Asynchronous current-limit level |
| out_a | output | 1 | Drive output for phase 0 |
| out_b | output | 1 | Drive output for phase 1 |
| phase | output | 1 | Current steering phase |

## Verification
The bench sweeps every duty command from 0 to beyond the period. This catches an off-by-one at either end of the compare window: such an error shows up as a one-cycle sliver at 0% duty, or as a pulse that spills into the blanking interval. It changes the command in the middle of periods, where a design that is not sampled at the restart would emit a second edge. It also toggles the current-limit input every cycle inside the window, where a missing per-period latch would give a string of short pulses. Finally, it drops and releases shutdown both in the middle of a pulse and across a period boundary. A steering flip-flop that toggles blindly every period would then fire the same output twice in a row. Restart strobes of one to three cycles, arriving earlier than the natural wrap, check that a period ends early and that a held strobe restarts only once.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

    // Steering phase: which output owns the pulse of the current period.
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    // Asynchronous control levels, grouped so they share one synchronizer.
    typedef struct packed {
        logic sync;
        logic shdn;
        logic ilim;
    } ctl_t;

    localparam int unsigned CTL_W      = $bits(ctl_t);
    localparam int unsigned SYNC_DEPTH = 2;

    // Route a pulse to the output that the phase selects: {b, a}.
    function automatic logic [1:0] steer(input logic pulse, input phase_e ph);
        return {pulse & (ph == PH_B), pulse & (ph == PH_A)};
    endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pp_ramp.sv
module pp_ramp #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PERIOD = 100,
    parameter int unsigned DEAD   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_lvl,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_q,
    output logic             wrap,
    output logic             blank
);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] DEAD_C = CNT_W'(DEAD);

    logic sync_d;
    logic sync_rise;

    assign sync_rise = sync_lvl & ~sync_d;
    assign wrap      = (cnt == LAST) | sync_rise;
    assign blank     = cnt < DEAD_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            duty_q <= '0;
            sync_d <= 1'b0;
        end else begin
            sync_d <= sync_lvl;
            if (wrap) begin
                cnt    <= '0;
                duty_q <= duty_cmd;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pp_steer.sv
module pp_steer
    import pp_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_q,
    input  logic             blank,
    input  logic             wrap,
    input  logic             stop,
    output logic             out_a,
    output logic             out_b,
    output phase_e           ph,
    output logic             term
);
    logic window;
    logic pulse;
    logic fired;

    assign window         = ~blank & (cnt < duty_q);
    assign pulse          = window & ~stop & ~term;
    assign {out_b, out_a} = steer(pulse, ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_A;
            fired <= 1'b0;
            term  <= 1'b0;
        end else if (wrap) begin
            if (fired | pulse) ph <= (ph == PH_A) ? PH_B : PH_A;
            fired <= 1'b0;
            term  <= 1'b0;
        end else begin
            fired <= fired | pulse;
            if (fired & ~pulse) term <= 1'b1;
        end
    end
endmodule

// File: rtl/pp_pwm_steer.sv
module pp_pwm_steer
    import pp_pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PERIOD = 100,
    parameter int unsigned DEAD   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             sync_in,
    input  logic             shdn_in,
    input  logic             ilim_in,
    output logic             out_a,
    output logic             out_b,
    output logic             phase
);
    ctl_t             raw;
    ctl_t             syn;
    logic [CTL_W-1:0] syn_vec;
    logic             s_stop;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_q;
    logic             wrap;
    logic             blank;
    logic             term;
    phase_e           ph;

    assign raw    = '{sync: sync_in, shdn: shdn_in, ilim: ilim_in};
    assign syn    = ctl_t'(syn_vec);
    assign s_stop = syn.shdn | syn.ilim;
    assign phase  = ph;

    pp_sync #(.W(CTL_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_vec)
    );

    pp_ramp #(.CNT_W(CNT_W), .PERIOD(PERIOD), .DEAD(DEAD)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .sync_lvl (syn.sync),
        .duty_cmd (duty_cmd),
        .cnt      (cnt),
        .duty_q   (duty_q),
        .wrap     (wrap),
        .blank    (blank)
    );

    pp_steer #(.CNT_W(CNT_W)) u_steer (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt),
        .duty_q (duty_q),
        .blank  (blank),
        .wrap   (wrap),
        .stop   (s_stop),
        .out_a  (out_a),
        .out_b  (out_b),
        .ph     (ph),
        .term   (term)
    );
endmodule

// File: rtl/pp_pwm_chk.sv
module pp_pwm_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PERIOD = 100,
    parameter int unsigned DEAD   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] duty_q,
    input logic             s_stop,
    input logic             phase,
    input logic             out_a,
    input logic             out_b
);
    localparam logic [CNT_W-1:0] DEAD_C = CNT_W'(DEAD);
    localparam logic [CNT_W-1:0] PER_C  = CNT_W'(PERIOD);

    // R2
    ramp_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < PER_C);

    // R3
    blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt < DEAD_C) |-> (!out_a && !out_b));

    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(duty_q));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b));

    // R7
    phase_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase) |-> (cnt == '0));

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        s_stop |-> (!out_a && !out_b));

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_a || out_b) |=> !(out_a || out_b));
endmodule

bind pp_pwm_steer pp_pwm_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD), .DEAD(DEAD)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt),
    .duty_q (duty_q),
    .s_stop (s_stop),
    .phase  (phase),
    .out_a  (out_a),
    .out_b  (out_b)
);

// File: tb/test_pp_pwm_steer.sv
module test_pp_pwm_steer;
    localparam int P = 16;
    localparam int D = 2;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] duty = '0;
    logic         sync_in = 1'b0;
    logic         shdn_in = 1'b0;
    logic         ilim_in = 1'b0;
    logic         out_a;
    logic         out_b;
    logic         phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected-behaviour state, built from the requirements
    int r = 0, dq = 0, ph = 0, pulsed = 0, ended = 0;
    int sy1 = 0, sy2 = 0, sy3 = 0, st1 = 0, st2 = 0;
    int exp_pulse = 0;
    int last_out = 2;
    logic prev_a = 1'b0, prev_b = 1'b0;

    always #2 clk = ~clk;

    pp_pwm_steer #(.CNT_W(W), .PERIOD(P), .DEAD(D)) i_pp_pwm_steer (
        .clk      (clk),
        .rst      (rst),
        .duty_cmd (duty),
        .sync_in  (sync_in),
        .shdn_in  (shdn_in),
        .ilim_in  (ilim_in),
        .out_a    (out_a),
        .out_b    (out_b),
        .phase    (phase)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (ramp %0d)", tag, what, act, exp, r);
        end
    endtask

    task automatic model_edge();
        int wrap;
        wrap = (r == P - 1) || (sy2 != 0 && sy3 == 0);
        if (wrap != 0) begin
            if (pulsed != 0 || exp_pulse != 0) ph = 1 - ph;
            r = 0; dq = int'(duty); pulsed = 0; ended = 0;
        end else begin
            r++;
            if (pulsed != 0 && exp_pulse == 0) ended = 1;
            if (exp_pulse != 0) pulsed = 1;
        end
        sy3 = sy2; sy2 = sy1; sy1 = int'(sync_in);
        st2 = st1; st1 = int'(shdn_in | ilim_in);
        exp_pulse = (r >= D && r < dq && st2 == 0 && ended == 0) ? 1 : 0;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "out_a", int'(out_a), (exp_pulse != 0 && ph == 0) ? 1 : 0);
        check(tag, "out_b", int'(out_b), (exp_pulse != 0 && ph == 1) ? 1 : 0);
        check("R7", "phase", int'(phase), ph);
        check("R6", "overlap", int'(out_a & out_b), 0);
        if (r < D) check("R3", "blank", int'(out_a | out_b), 0);
        if (out_a && !prev_a) begin
            check("R10", "repeat on a", (last_out == 0) ? 1 : 0, 0);
            last_out = 0;
        end
        if (out_b && !prev_b) begin
            check("R10", "repeat on b", (last_out == 1) ? 1 : 0, 0);
            last_out = 1;
        end
        prev_a = out_a;
        prev_b = out_b;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_a in reset", int'(out_a), 0);
        check("R1", "out_b in reset", int'(out_b), 0);
        check("R1", "phase in reset", int'(phase), 0);
        rst = 1'b0;
        step("R1");

        // R2: free running with a fixed command
        duty = W'(10);
        repeat (3 * P) step("R2");

        // R4: sweep every command value past the period
        for (int d = 0; d <= P + 2; d++) begin
            duty = W'(d);
            repeat (2 * P) step("R4");
        end

        // R5: command changes in mid period
        for (int i = 0; i < 6 * P; i++) begin
            step("R5");
            if (i % 5 == 0) duty = (duty == W'(12)) ? W'(3) : W'(12);
        end

        // R9: current limit chattering inside the window
        duty = W'(14);
        for (int i = 0; i < 5 * P; i++) begin
            step("R9");
            ilim_in = (r >= 4 && r < 12) ? ~ilim_in : 1'b0;
        end
        ilim_in = 1'b0;
        repeat (P) step("R9");

        // R8: shutdown during a pulse, held for several periods
        duty = W'(12);
        while (r != 6) step("R8");
        shdn_in = 1'b1;
        repeat (3 * P + 5) step("R8");
        shdn_in = 1'b0;
        repeat (3 * P) step("R10");

        // R10: short shutdown straddling a period boundary
        while (r != P - 3) step("R10");
        shdn_in = 1'b1;
        repeat (P) step("R10");
        shdn_in = 1'b0;
        repeat (3 * P) step("R10");

        // R11: restart strobes of one to three cycles, earlier than the wrap
        duty = W'(9);
        for (int k = 0; k < 9; k++) begin
            repeat (12) step("R11");
            sync_in = 1'b1;
            repeat (1 + k % 3) step("R11");
            sync_in = 1'b0;
        end
        sync_in = 1'b1;
        repeat (3 * P) step("R11");
        sync_in = 1'b0;
        repeat (2 * P) step("R11");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule